// File: doc/BRIEF.md
# Misprediction-Driven Fetch Throttle

This block sits next to the instruction fetch stage of a pipelined processor that executes speculatively. Each time a branch resolves, the resolution logic reports it, and the report says whether the prediction was wrong. The block keeps a saturating count of wrong predictions. When the count rises above a programmable limit, the block drops its fetch-enable output for a programmable number of cycles. This keeps the front end from spending energy on instructions that will probably be squashed.

When a suspension window opens, the counter restarts. The next window therefore needs a fresh run of wrong predictions. The window length is captured at the moment the window opens. A window cannot be restarted while it is already running. Wrong predictions that resolve during a window still accumulate toward the next one.

Top module: `fetch_gate_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `fetch_en` is 1, `gate_active` is 0 and the wrong-prediction count is zero. With `miss_limit` = 0, one wrong prediction is then enough to open a window.
- R2: The count only increases in a cycle where `br_done` = 1 and `br_wrong` = 1. A cycle where `br_wrong` = 1 and `br_done` = 0 leaves the count unchanged. So does a correct resolution (`br_done` = 1, `br_wrong` = 0).
- R3: A window opens only when the registered count is strictly greater than `miss_limit`. A count equal to the limit opens nothing.
- R4: Suppose the registered count exceeds the limit in cycle t while no window is running. Then `fetch_en` is 0 for exactly `hold_len` cycles, starting with cycle t+1. After that, `fetch_en` returns to 1 without any further input.
- R5: `gate_active` is 1 in exactly the cycles where `fetch_en` is 0.
- R6: The count is cleared when a window opens, so the next window needs a new run of more than `miss_limit` wrong predictions.
- R7: A wrong prediction that resolves in the same cycle as a window opens is kept. The count starts the new run at 1.
- R8: The count saturates at 2^CNT_W-1 and does not wrap.
- R9: When `hold_len` is 0 at the moment of triggering, no suspension cycle occurs, but the count is still cleared.
- R10: `hold_len` is captured when the window opens. Changing it while the window is running does not change that window's length.
- R11: No new window opens while one is running. Wrong predictions that resolve during a window still raise the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_done | input | 1 | Strobe: a branch has resolved this cycle |
| br_wrong | input | 1 | With br_done, the resolved branch was mispredicted |
| miss_limit | input | CNT_W | Count must exceed this value to trigger |
| hold_len | input | LEN_W | Number of suspended cycles per window |
| fetch_en | output | 1 | 1 = fetch may proceed |
| gate_active | output | 1 | 1 = a suspension window is running |

## Verification
Two counter updates can fall in the same cycle: the clear caused by a window opening, and the increment from a wrong resolution. The bench provokes this by sending a mispredict strobe in exactly the cycle where the count already exceeds the limit. It judges the outcome at the ports. After the window ends, a single further wrong prediction must be enough to open the next window. The bench also applies the saturation stimulus while a long window is running. This shows at the ports whether the count wrapped: a saturated count retriggers at once when the window ends.

// File: rtl/fgate_pkg.sv
package fgate_pkg;

    // Next-state selector for the wrong-prediction counter
    typedef enum logic [1:0] {
        CNT_KEEP = 2'd0,
        CNT_STEP = 2'd1,
        CNT_ZERO = 2'd2,
        CNT_ONE  = 2'd3
    } cnt_op_e;

    // Next-state selector for the suspension timer
    typedef enum logic [1:0] {
        TMR_REST = 2'd0,
        TMR_LOAD = 2'd1,
        TMR_TICK = 2'd2
    } tmr_op_e;

    // Control bundle produced by the trigger decision each cycle
    typedef struct packed {
        logic    fire;
        cnt_op_e cnt_op;
        tmr_op_e tmr_op;
    } gate_ctl_t;

    function automatic cnt_op_e pick_cnt_op(input logic fire, input logic miss_evt);
        if (fire)
            return miss_evt ? CNT_ONE : CNT_ZERO;
        return miss_evt ? CNT_STEP : CNT_KEEP;
    endfunction

endpackage

// File: rtl/gate_trigger.sv
module gate_trigger
    import fgate_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] limit,
    input  logic             busy,
    input  logic             miss_evt,
    output gate_ctl_t        ctl
);

    always_comb begin
        ctl.fire   = !busy && (cnt_q > limit);
        ctl.cnt_op = pick_cnt_op(ctl.fire, miss_evt);
        if (ctl.fire)
            ctl.tmr_op = TMR_LOAD;
        else if (busy)
            ctl.tmr_op = TMR_TICK;
        else
            ctl.tmr_op = TMR_REST;
    end

endmodule

// File: rtl/miss_counter.sv
module miss_counter
    import fgate_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                CNT_STEP: if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
                CNT_ZERO: cnt_q <= '0;
                CNT_ONE:  cnt_q <= CNT_W'(1);
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/gate_timer.sv
module gate_timer
    import fgate_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_op_e          op,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] tmr_q,
    output logic             busy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            unique case (op)
                TMR_LOAD: tmr_q <= len;
                TMR_TICK: tmr_q <= tmr_q - 1'b1;
                default:  tmr_q <= tmr_q;
            endcase
        end
    end

    assign busy = (tmr_q != '0);

endmodule

// File: rtl/fetch_gate_ctrl.sv
module fetch_gate_ctrl
    import fgate_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_done,
    input  logic             br_wrong,
    input  logic [CNT_W-1:0] miss_limit,
    input  logic [LEN_W-1:0] hold_len,
    output logic             fetch_en,
    output logic             gate_active
);

    logic             miss_evt;
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] tmr_q;
    logic             busy;
    logic             fire;
    gate_ctl_t        ctl;

    assign miss_evt = br_done & br_wrong;

    gate_trigger #(.CNT_W(CNT_W)) u_trig (
        .cnt_q    (cnt_q),
        .limit    (miss_limit),
        .busy     (busy),
        .miss_evt (miss_evt),
        .ctl      (ctl)
    );

    assign fire = ctl.fire;

    miss_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .op    (ctl.cnt_op),
        .cnt_q (cnt_q)
    );

    gate_timer #(.LEN_W(LEN_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .op    (ctl.tmr_op),
        .len   (hold_len),
        .tmr_q (tmr_q),
        .busy  (busy)
    );

    assign fetch_en    = !busy;
    assign gate_active = busy;

endmodule

// File: rtl/fgate_checker.sv
module fgate_checker #(
    parameter int CNT_W = 4,
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             br_done,
    input logic             br_wrong,
    input logic [CNT_W-1:0] miss_limit,
    input logic [LEN_W-1:0] hold_len,
    input logic             fetch_en,
    input logic             gate_active,
    input logic [CNT_W-1:0] cnt_q,
    input logic [LEN_W-1:0] tmr_q,
    input logic             fire
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_en && !gate_active && cnt_q == '0));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!(br_done && br_wrong) && !fire) |=> $stable(cnt_q));

    a_r3_no_open_at_limit: assert property (@(posedge clk) disable iff (rst)
        (tmr_q == '0 && cnt_q <= miss_limit) |=> !gate_active);

    a_r4_timer_counts_down: assert property (@(posedge clk) disable iff (rst)
        (tmr_q != '0) |=> (tmr_q == LEN_W'($past(tmr_q) - 1'b1)));

    a_r6_clear_on_open: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt_q <= CNT_W'(1)));

    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_TOP && !fire) |=> (cnt_q == CNT_TOP));

    a_r10_len_captured: assert property (@(posedge clk) disable iff (rst)
        fire |=> (tmr_q == $past(hold_len)));

    a_r11_no_reopen: assert property (@(posedge clk) disable iff (rst)
        (tmr_q != '0) |-> !fire);

endmodule

bind fetch_gate_ctrl fgate_checker #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .br_done     (br_done),
    .br_wrong    (br_wrong),
    .miss_limit  (miss_limit),
    .hold_len    (hold_len),
    .fetch_en    (fetch_en),
    .gate_active (gate_active),
    .cnt_q       (cnt_q),
    .tmr_q       (tmr_q),
    .fire        (fire)
);

// File: tb/sim_fetch_gate_ctrl.sv
module sim_fetch_gate_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int LEN_W      = 8;
    localparam int CNT_TOP    = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             br_done = 1'b0;
    logic             br_wrong = 1'b0;
    logic [CNT_W-1:0] miss_limit = '0;
    logic [LEN_W-1:0] hold_len = '0;
    logic             fetch_en;
    logic             gate_active;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_gate_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .br_done     (br_done),
        .br_wrong    (br_wrong),
        .miss_limit  (miss_limit),
        .hold_len    (hold_len),
        .fetch_en    (fetch_en),
        .gate_active (gate_active)
    );

    typedef struct {
        int unsigned tag;
        bit          fe;
        bit          ga;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    // Behavioural model state, built from the requirements
    int m_cnt = 0;
    int m_tim = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare outputs mid-cycle against queued expectations
    always @(negedge clk) begin
        while (sb.size() != 0 && sb[0].tag == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (fetch_en !== e.fe || gate_active !== e.ga) begin
                errors++;
                $display("FAIL %s cyc=%0d: fetch_en=%0b gate_active=%0b expected fetch_en=%0b gate_active=%0b",
                         e.req, cyc, fetch_en, gate_active, e.fe, e.ga);
            end
        end
    end

    // Driver: called just after a rising edge; applies inputs and queues the
    // outputs expected after the next rising edge.
    task automatic step(input bit v, input bit m, input string req);
        bit trig;
        bit miss;
        br_done  = v;
        br_wrong = m;
        miss = v && m;
        trig = (m_tim == 0) && (m_cnt > int'(miss_limit));
        if (trig) begin
            m_cnt = miss ? 1 : 0;
            m_tim = int'(hold_len);
        end else begin
            if (m_tim != 0) m_tim = m_tim - 1;
            if (miss && m_cnt < CNT_TOP) m_cnt = m_cnt + 1;
        end
        sb.push_back('{cyc + 1, (m_tim == 0), (m_tim != 0), req});
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        m_cnt = 0;
        m_tim = 0;

        // R1: reset state at the ports
        @(negedge clk);
        checks++;
        if (fetch_en !== 1'b1 || gate_active !== 1'b0) begin
            errors++;
            $display("FAIL R1: fetch_en=%0b gate_active=%0b expected 1 0", fetch_en, gate_active);
        end
        @(posedge clk);
        #1;

        // R1: counter starts at zero, so one miss exceeds limit 0
        miss_limit = 4'd0;
        hold_len   = 8'd2;
        step(1'b1, 1'b1, "R1");
        idle(4, "R4");

        // R2 and R3: ignored strobes, then equality does not trigger
        miss_limit = 4'd2;
        hold_len   = 8'd3;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R2");
        step(1'b1, 1'b1, "R2");
        step(1'b1, 1'b1, "R3");
        idle(3, "R3");
        step(1'b1, 1'b1, "R4");
        idle(5, "R4");

        // R7: mispredict coincident with window opening is kept
        miss_limit = 4'd1;
        hold_len   = 8'd2;
        step(1'b1, 1'b1, "R7");
        step(1'b1, 1'b1, "R7");
        step(1'b1, 1'b1, "R7");
        idle(3, "R7");
        step(1'b1, 1'b1, "R7");
        idle(4, "R7");

        // R10 and R5: length changed mid-window has no effect
        miss_limit = 4'd0;
        hold_len   = 8'd4;
        step(1'b1, 1'b1, "R10");
        step(1'b0, 1'b0, "R10");
        hold_len = 8'd1;
        idle(6, "R5");

        // R9: zero length, counter still cleared
        miss_limit = 4'd0;
        hold_len   = 8'd0;
        step(1'b1, 1'b1, "R9");
        idle(3, "R9");
        miss_limit = 4'd1;
        hold_len   = 8'd2;
        step(1'b1, 1'b1, "R9");
        idle(2, "R9");
        // R6: second miss of the fresh run opens the next window
        step(1'b1, 1'b1, "R6");
        idle(4, "R6");

        // R11 and R8: flood misses inside a long window, then retrigger
        miss_limit = 4'd0;
        hold_len   = 8'd40;
        step(1'b1, 1'b1, "R11");
        step(1'b0, 1'b0, "R11");
        miss_limit = 4'd14;
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, "R11");
        idle(50, "R8");

        idle(2, "R5");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule